// File: doc/BRIEF.md
# Per-Function Hardware Profiler Core

This block sits beside a 32-bit soft processor and measures where run time goes, split by software function. It does not touch the processor. It watches the program counter, the valid-PC strobe, the instruction word and the stall line. It also takes a function index for the call target, which an external hashing unit computes. From these inputs it keeps one running event count for the function that is currently executing.

On every function call or return, the running count is folded into that function's entry in a totals RAM by read-modify-write, and the count restarts at zero. A small stack of function indices remembers the caller, so that a return restores the right context.

When profiling is switched off, a host reads the per-function totals through a simple indexed read port. The host can also wipe all entries with a clear strobe.

Top module: `prof_core`

## Requirements
- R1: A call is a new instruction whose opcode (bits 31:26) is 000011, or whose opcode is 000000 with function field (bits 5:0) 001001. A return is opcode 000000 with function field 001000 and register field (bits 25:21) equal to 31. A jump-register instruction naming any other register is neither. An instruction held on the bus with an unchanged PC is decoded only once.
- R2: With mode 0, the running count advances once for each cycle in which `pc_valid` is high and `pc` differs from the previous valid PC. The first valid PC after reset counts.
- R3: Mode 1 counts every clock cycle. Mode 2 counts every cycle with `stall` high, whether or not the PC is valid. Mode 3 counts nothing.
- R4: On a call, the running count plus any event in that same cycle is added to the current function's entry. The count restarts at zero, the current index is pushed, and `tgt_idx` becomes the current function.
- R5: On a return, the running count plus any same-cycle event is added to the current function's entry. The count restarts at zero, and the index popped from the stack becomes the current function.
- R6: Entries accumulate across any number of calls to and returns from the same function.
- R7: A call or return that arrives while the previous read-modify-write is in its read cycle is held in a one-entry pending slot and applied afterwards, not dropped.
- R8: A push onto a full stack is dropped and sets `stk_ovf`, which stays set until reset.
- R9: A pop from an empty stack sets `stk_udf`, which stays set until reset. The current function index stays unchanged.
- R10: `rd_data` shows the entry selected by `rd_idx` one clock later.
- R11: With `prof_en` low, a `clr_req` pulse holds `clr_busy` high for exactly N cycles and zeroes every entry. With `prof_en` high, `clr_req` is ignored.
- R12: After reset, every entry reads zero, both stack flags are low, the current index is 0 and the running count is 0.
- R13: With `prof_en` low, no events are counted and no call or return is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prof_en | input | 1 | Profiling enable |
| ev_mode | input | 2 | Event select: 0 instructions, 1 cycles, 2 stall cycles, 3 none |
| pc_valid | input | 1 | Program counter is valid this cycle |
| pc | input | PCW | Program counter |
| instr | input | 32 | Executing instruction word |
| stall | input | 1 | Processor stall |
| tgt_idx | input | log2(N) | Hashed function index of the call target |
| rd_idx | input | log2(N) | Host read index |
| rd_data | output | CW | Total for entry `rd_idx`, one cycle late |
| clr_req | input | 1 | Clear-all strobe |
| clr_busy | output | 1 | Clear in progress |
| stk_ovf | output | 1 | Sticky stack overflow |
| stk_udf | output | 1 | Sticky stack underflow |

## Verification
The bench runs short call/return programs and compares every RAM entry against a bench model. Straight-line code with a stalled, repeated PC separates instruction counting from cycle counting. Gaps with `pc_valid` low and stall pulses on invalid cycles separate cycle counting from stall counting. A jump through a register other than 31 shows it is not treated as a return.

Repeated calls to one function check that entries accumulate rather than overwrite. Call and return in adjacent cycles push traffic through the pending slot. Thirty-three nested calls, each unwound by a return, drive the stack into both overflow and underflow. The clear is tried with profiling both enabled and disabled.

// File: rtl/prof_pkg.sv
package prof_pkg;

    typedef enum logic [1:0] {
        EV_INSTR = 2'd0,
        EV_CYCLE = 2'd1,
        EV_STALL = 2'd2,
        EV_NONE  = 2'd3
    } ev_mode_e;

    typedef enum logic [1:0] {
        RMW_IDLE  = 2'd0,
        RMW_READ  = 2'd1,
        RMW_WRITE = 2'd2
    } rmw_st_e;

    localparam logic [5:0] OP_SPECIAL = 6'b000000;
    localparam logic [5:0] OP_JAL     = 6'b000011;
    localparam logic [5:0] FN_JR      = 6'b001000;
    localparam logic [5:0] FN_JALR    = 6'b001001;
    localparam logic [4:0] RA_REG     = 5'd31;

    function automatic logic op_is_call(input logic [31:0] w);
        return (w[31:26] == OP_JAL) ||
               (w[31:26] == OP_SPECIAL && w[5:0] == FN_JALR);
    endfunction

    function automatic logic op_is_ret(input logic [31:0] w);
        return (w[31:26] == OP_SPECIAL) && (w[5:0] == FN_JR) &&
               (w[25:21] == RA_REG);
    endfunction

endpackage

// File: rtl/prof_decoder.sv
module prof_decoder
    import prof_pkg::*;
#(
    parameter int PCW = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic           pc_valid,
    input  logic [PCW-1:0] pc,
    input  logic [31:0]    instr,
    output logic           new_instr,
    output logic           call,
    output logic           ret
);
    logic [PCW-1:0] last_pc;
    logic           have_last;

    assign new_instr = pc_valid && (!have_last || pc != last_pc);
    assign call      = en && new_instr && op_is_call(instr);
    assign ret       = en && new_instr && op_is_ret(instr);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_pc   <= '0;
            have_last <= 1'b0;
        end else if (pc_valid) begin
            last_pc   <= pc;
            have_last <= 1'b1;
        end
    end

    // R1: a held PC never produces a second call or return
    p_once_per_pc_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && pc_valid && $past(pc_valid) && pc == $past(pc)) |-> !(call || ret));

    // R1: never both at once
    p_call_ret_excl_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({call, ret}));

endmodule

// File: rtl/prof_event_counter.sv
module prof_event_counter
    import prof_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  ev_mode_e      mode,
    input  logic          new_instr,
    input  logic          stall,
    input  logic          switch_ctx,
    output logic [CW-1:0] amount
);
    logic [CW-1:0] dcnt;
    logic          ev;

    always_comb begin
        unique case (mode)
            EV_INSTR: ev = new_instr;
            EV_CYCLE: ev = 1'b1;
            EV_STALL: ev = stall;
            default:  ev = 1'b0;
        endcase
        ev = ev && en;
    end

    // the cycle's own event belongs to the context being left
    assign amount = dcnt + CW'(ev);

    always_ff @(posedge clk) begin
        if (rst)             dcnt <= '0;
        else if (switch_ctx) dcnt <= '0;
        else if (ev)         dcnt <= dcnt + 1'b1;
    end

    p_restart_r4: assert property (@(posedge clk) disable iff (rst)
        switch_ctx |=> (dcnt == '0));

    p_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (!en && !switch_ctx) |=> $stable(dcnt));

endmodule

// File: rtl/prof_call_stack.sv
module prof_call_stack #(
    parameter int IW    = 6,
    parameter int DEPTH = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [IW-1:0] push_idx,
    output logic [IW-1:0] top_idx,
    output logic          empty,
    output logic          ovf,
    output logic          udf
);
    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int SPW = $clog2(DEPTH + 1);

    logic [IW-1:0]  slots [DEPTH];
    logic [SPW-1:0] sp;
    logic           full;

    assign full    = (sp == SPW'(DEPTH));
    assign empty   = (sp == '0);
    assign top_idx = slots[AW'(sp - 1'b1)];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp  <= '0;
            ovf <= 1'b0;
            udf <= 1'b0;
        end else if (push) begin
            if (full) begin
                ovf <= 1'b1;
            end else begin
                slots[AW'(sp)] <= push_idx;
                sp             <= sp + 1'b1;
            end
        end else if (pop) begin
            if (empty) udf <= 1'b1;
            else       sp  <= sp - 1'b1;
        end
    end

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst) ovf |=> ovf);
    p_udf_sticky_r9: assert property (@(posedge clk) disable iff (rst) udf |=> udf);
    p_push_full_r8: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> ($stable(sp) && ovf));
    p_pop_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && empty) |=> (sp == '0 && udf));

endmodule

// File: rtl/prof_totals.sv
module prof_totals
    import prof_pkg::*;
#(
    parameter  int CW = 32,
    parameter  int N  = 64,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          req_valid,
    input  logic [IW-1:0] req_idx,
    input  logic [CW-1:0] req_amt,
    input  logic          clr_req,
    output logic          clr_busy,
    input  logic [IW-1:0] rd_idx,
    output logic [CW-1:0] rd_data
);
    logic [CW-1:0] mem [N];

    rmw_st_e       st;
    logic [IW-1:0] op_idx;
    logic [CW-1:0] op_amt;
    logic [CW-1:0] rd_q;

    logic          pend_v;
    logic [IW-1:0] pend_idx;
    logic [CW-1:0] pend_amt;

    logic [IW-1:0] clr_ptr;
    logic          can_accept, take_pend, take_req, park_req, clr_start;

    // a new operation may start alongside the previous write cycle
    assign can_accept = (st != RMW_READ) && !clr_busy;
    assign take_pend  = pend_v && can_accept;
    assign take_req   = req_valid && can_accept && !pend_v;
    assign park_req   = req_valid && !take_req;
    assign clr_start  = clr_req && !en && !clr_busy && (st == RMW_IDLE) && !pend_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= RMW_IDLE;
            op_idx   <= '0;
            op_amt   <= '0;
            rd_q     <= '0;
            pend_v   <= 1'b0;
            pend_idx <= '0;
            pend_amt <= '0;
            clr_busy <= 1'b0;
            clr_ptr  <= '0;
            rd_data  <= '0;
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else begin
            rd_data <= mem[rd_idx];

            if (st == RMW_READ)  rd_q <= mem[op_idx];
            if (st == RMW_WRITE) mem[op_idx] <= rd_q + op_amt;

            if (take_pend) begin
                op_idx <= pend_idx;
                op_amt <= pend_amt;
            end else if (take_req) begin
                op_idx <= req_idx;
                op_amt <= req_amt;
            end

            if (take_pend || take_req) st <= RMW_READ;
            else if (st == RMW_READ)   st <= RMW_WRITE;
            else                       st <= RMW_IDLE;

            if (park_req) begin
                pend_v   <= 1'b1;
                pend_idx <= req_idx;
                pend_amt <= req_amt;
            end else if (take_pend) begin
                pend_v   <= 1'b0;
            end

            if (clr_start) begin
                clr_busy <= 1'b1;
                clr_ptr  <= '0;
            end else if (clr_busy) begin
                mem[clr_ptr] <= '0;
                clr_ptr      <= clr_ptr + 1'b1;
                if (clr_ptr == IW'(N - 1)) clr_busy <= 1'b0;
            end
        end
    end

    p_read_then_write_r7: assert property (@(posedge clk) disable iff (rst)
        (st == RMW_READ) |=> (st == RMW_WRITE));
    p_no_loss_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && pend_v) |-> can_accept);
    p_parked_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && st == RMW_READ) |=> pend_v);
    p_clear_runs_r11: assert property (@(posedge clk) disable iff (rst)
        (clr_busy && clr_ptr != IW'(N - 1)) |=> clr_busy);
    p_clear_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (clr_req && en && !clr_busy) |=> !clr_busy);

endmodule

// File: rtl/prof_core.sv
module prof_core
    import prof_pkg::*;
#(
    parameter  int CW    = 32,
    parameter  int N     = 64,
    parameter  int DEPTH = 32,
    parameter  int PCW   = 32,
    localparam int IW    = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           prof_en,
    input  logic [1:0]     ev_mode,
    input  logic           pc_valid,
    input  logic [PCW-1:0] pc,
    input  logic [31:0]    instr,
    input  logic           stall,
    input  logic [IW-1:0]  tgt_idx,
    input  logic [IW-1:0]  rd_idx,
    output logic [CW-1:0]  rd_data,
    input  logic           clr_req,
    output logic           clr_busy,
    output logic           stk_ovf,
    output logic           stk_udf
);
    logic          new_instr, is_call, is_ret, sw;
    logic [CW-1:0] amount;
    logic [IW-1:0] cur_idx, top_idx;
    logic          stk_empty;
    ev_mode_e      mode_e;

    assign mode_e = ev_mode_e'(ev_mode);
    assign sw     = is_call || is_ret;

    prof_decoder #(.PCW(PCW)) u_dec (
        .clk, .rst, .en(prof_en), .pc_valid, .pc, .instr,
        .new_instr, .call(is_call), .ret(is_ret)
    );

    prof_event_counter #(.CW(CW)) u_cnt (
        .clk, .rst, .en(prof_en), .mode(mode_e), .new_instr, .stall,
        .switch_ctx(sw), .amount
    );

    prof_call_stack #(.IW(IW), .DEPTH(DEPTH)) u_stk (
        .clk, .rst, .push(is_call), .pop(is_ret), .push_idx(cur_idx),
        .top_idx, .empty(stk_empty), .ovf(stk_ovf), .udf(stk_udf)
    );

    prof_totals #(.CW(CW), .N(N)) u_tot (
        .clk, .rst, .en(prof_en), .req_valid(sw), .req_idx(cur_idx),
        .req_amt(amount), .clr_req, .clr_busy, .rd_idx, .rd_data
    );

    always_ff @(posedge clk) begin
        if (rst)                       cur_idx <= '0;
        else if (is_call)              cur_idx <= tgt_idx;
        else if (is_ret && !stk_empty) cur_idx <= top_idx;
    end

    p_call_target_r4: assert property (@(posedge clk) disable iff (rst)
        is_call |=> (cur_idx == $past(tgt_idx)));
    p_ret_restore_r5: assert property (@(posedge clk) disable iff (rst)
        (is_ret && !stk_empty) |=> (cur_idx == $past(top_idx)));
    p_ret_empty_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (is_ret && stk_empty) |=> $stable(cur_idx));

endmodule

// File: tb/sim_prof_core.sv
module sim_prof_core;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 64;
    localparam int D  = 32;
    localparam int CW = 32;
    localparam int IW = $clog2(N);

    localparam logic [31:0] I_NOP  = 32'h0000_0000;
    localparam logic [31:0] I_JAL  = 32'h0C00_0040;
    localparam logic [31:0] I_JALR = 32'h0040_F809;
    localparam logic [31:0] I_RET  = 32'h03E0_0008;
    localparam logic [31:0] I_JR2  = 32'h0040_0008;

    logic          clk = 1'b0, rst, prof_en, pc_valid, stall, clr_req;
    logic [1:0]    ev_mode;
    logic [31:0]   pc, instr;
    logic [IW-1:0] tgt_idx, rd_idx;
    logic [CW-1:0] rd_data;
    logic          clr_busy, stk_ovf, stk_udf;

    prof_core #(.CW(CW), .N(N), .DEPTH(D), .PCW(32)) u0 (
        .clk, .rst, .prof_en, .ev_mode, .pc_valid, .pc, .instr, .stall,
        .tgt_idx, .rd_idx, .rd_data, .clr_req, .clr_busy, .stk_ovf, .stk_udf
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;
    always @(posedge clk) cyc++;

    typedef struct { logic [31:0] exp; int due; string tag; } item_t;
    item_t q[$];
    item_t it;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pops scoreboard items when their read result is due
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            it = q.pop_front();
            chk(it.tag, rd_data, it.exp);
        end
    end

    // reference model state
    logic [31:0] m_tot [N];
    int          m_cur, m_stk [D], m_sp;
    logic [31:0] m_cnt, m_last, m_pc, m_ins;
    bit          m_have, m_ovf, m_udf;

    task automatic step(bit v, logic [31:0] p, logic [31:0] ins, bit st, int tgt);
        bit nw, ev, cl, rt;
        pc_valid = v; pc = p; instr = ins; stall = st; tgt_idx = tgt[IW-1:0];
        nw = v && (!m_have || p != m_last);
        if (v) begin m_have = 1; m_last = p; end
        case (ev_mode)
            2'd0: ev = nw;
            2'd1: ev = 1;
            2'd2: ev = st;
            default: ev = 0;
        endcase
        ev = ev && prof_en;
        cl = prof_en && nw && (ins[31:26] == 6'h03 || (ins[31:26] == 6'h00 && ins[5:0] == 6'h09));
        rt = prof_en && nw && ins[31:26] == 6'h00 && ins[5:0] == 6'h08 && ins[25:21] == 5'd31;
        if (cl || rt) begin
            m_tot[m_cur] += m_cnt + 32'(ev);
            m_cnt = 0;
            if (cl) begin
                if (m_sp < D) begin m_stk[m_sp] = m_cur; m_sp++; end
                else m_ovf = 1;
                m_cur = tgt;
            end else begin
                if (m_sp > 0) begin m_sp--; m_cur = m_stk[m_sp]; end
                else m_udf = 1;
            end
        end else begin
            m_cnt += 32'(ev);
        end
        @(negedge clk);
    endtask

    task automatic nx(logic [31:0] ins, int tgt = 0);
        m_pc += 4; m_ins = ins;
        step(1, m_pc, ins, 0, tgt);
    endtask
    task automatic held(int n);
        for (int i = 0; i < n; i++) step(1, m_pc, m_ins, 1, 0);
    endtask
    task automatic idle(int n, bit st = 0);
        for (int i = 0; i < n; i++) step(0, m_pc, I_NOP, st, 0);
    endtask

    task automatic halt();
        prof_en = 0;
        idle(6);
    endtask

    task automatic readall(string tag);
        for (int i = 0; i < N; i++) begin
            rd_idx = i[IW-1:0];
            q.push_back('{m_tot[i], cyc + 1, $sformatf("%s entry %0d (R10)", tag, i)});
            @(negedge clk);
        end
        idle(2);
    endtask

    task automatic do_reset();
        rst = 1; prof_en = 0; ev_mode = 0; pc_valid = 0; pc = 0; instr = 0;
        stall = 0; clr_req = 0; tgt_idx = 0; rd_idx = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        for (int i = 0; i < N; i++) m_tot[i] = 0;
        m_cur = 0; m_sp = 0; m_cnt = 0; m_have = 0; m_last = 0;
        m_ovf = 0; m_udf = 0; m_pc = 32'h100; m_ins = I_NOP;
    endtask

    initial begin
        do_reset();
        // R12: reset state
        chk("R12 ovf", 32'(stk_ovf), 0);
        chk("R12 udf", 32'(stk_udf), 0);
        chk("R12 busy", 32'(clr_busy), 0);
        readall("R12 reset");

        // R1 R2 R4 R5: instruction counting through calls and returns
        prof_en = 1; ev_mode = 0;
        nx(I_NOP); nx(I_NOP); nx(I_NOP); nx(I_JAL, 5); nx(I_NOP); nx(I_NOP);
        held(3); nx(I_NOP); nx(I_RET); nx(I_NOP); nx(I_NOP);
        nx(I_JALR, 7); held(2); nx(I_NOP); nx(I_NOP); nx(I_JR2); nx(I_NOP);
        nx(I_RET); nx(I_NOP); nx(I_JAL, 8); nx(I_NOP);
        halt();
        readall("R1 R2 R4 R5 instr");

        // R3: cycle counting including invalid-PC gaps
        prof_en = 1; ev_mode = 1;
        nx(I_NOP); idle(3); nx(I_JAL, 9); idle(2); nx(I_NOP); nx(I_RET);
        idle(4); nx(I_JAL, 9); nx(I_NOP);
        halt();
        readall("R3 cycle");

        // R3: stall counting, then mode 3 counts nothing
        prof_en = 1; ev_mode = 2;
        nx(I_JAL, 11); held(4); nx(I_NOP); idle(2, 1); nx(I_RET); nx(I_NOP);
        ev_mode = 3;
        nx(I_JAL, 12); held(2); nx(I_NOP); nx(I_RET); nx(I_NOP);
        halt();
        readall("R3 stall none");

        // R6: repeated calls to one function accumulate
        prof_en = 1; ev_mode = 0;
        for (int k = 0; k < 3; k++) begin
            nx(I_JAL, 20); nx(I_NOP); nx(I_NOP); nx(I_RET); nx(I_NOP);
        end
        halt();
        readall("R6 accumulate");

        // R7: call and return on adjacent cycles
        prof_en = 1; ev_mode = 1;
        nx(I_JAL, 30); nx(I_RET); idle(2);
        nx(I_JAL, 31); nx(I_RET); idle(1);
        nx(I_JALR, 32); nx(I_RET);
        halt();
        readall("R7 pending");

        // R13: disabled profiler takes no events or switches
        prof_en = 0; ev_mode = 1;
        nx(I_JAL, 40); nx(I_NOP); nx(I_NOP); nx(I_RET); nx(I_NOP);
        prof_en = 1;
        nx(I_NOP); nx(I_JAL, 41); nx(I_NOP);
        halt();
        readall("R13 disabled");

        // R8 R9: stack overflow then underflow
        do_reset();
        prof_en = 1; ev_mode = 0;
        for (int i = 0; i < D + 1; i++) begin nx(I_JAL, i + 1); nx(I_NOP); end
        chk("R8 ovf set", 32'(stk_ovf), 1);
        chk("R9 udf clear", 32'(stk_udf), 0);
        for (int i = 0; i < D + 1; i++) begin nx(I_RET); nx(I_NOP); end
        chk("R9 udf set", 32'(stk_udf), 1);
        chk("R8 ovf sticky", 32'(stk_ovf), 1);
        nx(I_NOP); nx(I_JAL, 50); nx(I_NOP);
        halt();
        readall("R8 R9 stack");

        // R11: clear ignored while enabled, honoured while disabled
        prof_en = 1; ev_mode = 0;
        clr_req = 1; idle(1); clr_req = 0;
        chk("R11 ignored busy", 32'(clr_busy), 0);
        halt();
        readall("R11 kept");
        clr_req = 1; @(negedge clk); clr_req = 0;
        begin
            int nb = 0;
            for (int i = 0; i < 200; i++) begin
                if (clr_busy) nb++;
                @(negedge clk);
            end
            chk("R11 busy length", 32'(nb), 32'(N));
        end
        for (int i = 0; i < N; i++) m_tot[i] = 0;
        readall("R11 cleared");

        idle(3);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule